// File: doc/BRIEF.md
# Configuration Change Protection Unit

This block gates two kinds of sensitive operation behind a short, timed unlock. The first is a write to a critical control register. The second is the execution of a flash program or flash read instruction. Software opens a window by writing a signature byte to the protection register. The signature must come from the CPU. The byte value chooses the mode: 0xD8 unlocks the protected I/O registers and 0x9D unlocks the protected flash instructions. The window counts retired instructions, not clock cycles. It closes by itself after four of them.

While a window is open, the unit raises an interrupt-hold signal. The interrupt controller uses it to defer all servicing, including non-maskable requests. Those requests keep their pending flags and are taken in priority order once the hold drops. A signature written by the DMA master is discarded. DMA traffic during a window does not change its length. The flash mode ends at once if the CPU performs any data-memory write or executes a sleep instruction.

The register reads back a status byte. Bit 0 shows the I/O mode and bit 1 shows the flash mode. The upper bits always read zero.

Top module: `cfg_guard`

## Requirements
- R1: After reset both unlock flags are 0, irq_hold is 0 and rd_data is 0x00.
- R2: A CPU write (prot_wr_en=1, wr_is_dma=0) of 0xD8 sets io_unlock in the next cycle, and rd_data then reads 0x01.
- R3: A CPU write of 0x9D sets flash_unlock in the next cycle, and rd_data then reads 0x02.
- R4: An open window closes in the cycle after the fourth retire_strobe that follows the signature write. A retire strobe in the signature-write cycle itself is not counted.
- R5: With no retire strobes, an open window stays open for any number of clock cycles.
- R6: A write with wr_is_dma=1 never opens, changes, restarts or closes a window, whatever its value.
- R7: A CPU write of any value other than 0xD8 or 0x9D leaves the mode and the window count unchanged.
- R8: While flash_unlock is set, dmem_wr_strobe or sleep_strobe clears it in the next cycle. The I/O mode is not affected by either strobe.
- R9: A valid CPU signature written during an open window selects the new mode and restarts the count at zero. It takes precedence over cancellation and retirement in the same cycle. At most one unlock flag is ever set.
- R10: irq_hold is 1 exactly when io_unlock or flash_unlock is 1.
- R11: rd_data[7:2] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_wr_en | input | 1 | Write strobe to the protection register |
| wr_is_dma | input | 1 | The write comes from the DMA master (1) or the CPU (0) |
| wr_data | input | 8 | Write data |
| retire_strobe | input | 1 | One CPU instruction retired this cycle |
| dmem_wr_strobe | input | 1 | The CPU wrote data memory this cycle |
| sleep_strobe | input | 1 | The CPU executed a sleep instruction this cycle |
| rd_data | output | 8 | Status readback of the protection register |
| io_unlock | output | 1 | Protected I/O register writes enabled |
| flash_unlock | output | 1 | Protected flash instructions enabled |
| irq_hold | output | 1 | Defer interrupt servicing |

## Verification
The hardest situation to reach is several events landing on the same edge as the last counted retire. Examples are a restart signature, a flash cancel, or a DMA write of a signature. Each one changes which rule wins. Directed sequences step the window to its third retire and then apply each collision on purpose. Biased random traffic then adds many more chances: signatures are written often, retire strobes come on about half the cycles, and cancel strobes are rarer, so windows often run into their final count.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
   typedef enum logic [1:0] {
      LOCK_NONE  = 2'd0,
      LOCK_IO    = 2'd1,
      LOCK_FLASH = 2'd2
   } lock_mode_t;

   localparam int unsigned STAT_IO_BIT    = 0;
   localparam int unsigned STAT_FLASH_BIT = 1;
endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode
   import cfg_guard_pkg::*;
#(
   parameter int unsigned            DATA_W    = 8,
   parameter logic [DATA_W-1:0]      SIG_IO    = 8'hD8,
   parameter logic [DATA_W-1:0]      SIG_FLASH = 8'h9D
) (
   input  logic              wr_en,
   input  logic              wr_is_dma,
   input  logic [DATA_W-1:0] wr_data,
   output logic              open_req,
   output lock_mode_t        open_mode
);
   localparam int unsigned N_SIG = 2;

   logic [N_SIG-1:0] hit;
   logic             cpu_wr;

   assign cpu_wr = wr_en && !wr_is_dma;

   for (genvar s = 0; s < N_SIG; s++) begin : g_sig
      localparam logic [DATA_W-1:0] SIG = (s == 0) ? SIG_IO : SIG_FLASH;
      assign hit[s] = cpu_wr && (wr_data == SIG);
   end

   always_comb begin
      open_req  = |hit;
      open_mode = LOCK_NONE;
      if (hit[0])      open_mode = LOCK_IO;
      else if (hit[1]) open_mode = LOCK_FLASH;
   end
endmodule

// File: rtl/cfg_guard_window.sv
module cfg_guard_window
   import cfg_guard_pkg::*;
#(
   parameter int unsigned WINDOW = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       open_req,
   input  lock_mode_t open_mode,
   input  logic       retire,
   input  logic       cancel,
   output lock_mode_t mode
);
   localparam int unsigned CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

   logic          last_tick;
   logic          flash_kill;
   logic [CW-1:0] cnt;

   assign flash_kill = (mode == LOCK_FLASH) && cancel;

   if (WINDOW == 1) begin : g_single
      assign cnt       = '0;
      assign last_tick = retire;
   end else begin : g_counted
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (open_req || flash_kill || mode == LOCK_NONE)
            cnt_q <= '0;
         else if (retire)
            cnt_q <= (cnt_q == CW'(WINDOW - 1)) ? '0 : cnt_q + CW'(1);
      end
      assign cnt       = cnt_q;
      assign last_tick = retire && (cnt_q == CW'(WINDOW - 1));

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CW'(WINDOW - 1)); // R4
      AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (mode != LOCK_NONE && !retire && !open_req && !flash_kill)
         |=> $stable(cnt_q)); // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= LOCK_NONE;
      else if (open_req)
         mode <= open_mode;
      else if (flash_kill)
         mode <= LOCK_NONE;
      else if (mode != LOCK_NONE && last_tick)
         mode <= LOCK_NONE;
   end

   AST_CANCEL_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LOCK_FLASH && cancel && !open_req) |=> mode == LOCK_NONE); // R8
   AST_CANCEL_SPARES_IO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LOCK_IO && !retire && !open_req) |=> mode == LOCK_IO); // R8
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      open_req |=> mode == $past(open_mode)); // R9
   AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LOCK_NONE && !open_req) |=> mode == LOCK_NONE); // R7
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LOCK_NONE) |-> cnt == '0); // R4
endmodule

// File: rtl/cfg_guard_readback.sv
module cfg_guard_readback
   import cfg_guard_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  lock_mode_t        mode,
   output logic [DATA_W-1:0] rd_data
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == STAT_IO_BIT) begin : g_io
         assign rd_data[b] = (mode == LOCK_IO);
      end else if (b == STAT_FLASH_BIT) begin : g_fl
         assign rd_data[b] = (mode == LOCK_FLASH);
      end else begin : g_zero
         assign rd_data[b] = 1'b0;
      end
   end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
   import cfg_guard_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       WINDOW    = 4,
   parameter logic [DATA_W-1:0] SIG_IO    = 8'hD8,
   parameter logic [DATA_W-1:0] SIG_FLASH = 8'h9D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_wr_en,
   input  logic              wr_is_dma,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              retire_strobe,
   input  logic              dmem_wr_strobe,
   input  logic              sleep_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic              io_unlock,
   output logic              flash_unlock,
   output logic              irq_hold
);
   if (DATA_W < 2) begin : g_bad_width
      $error("cfg_guard: DATA_W must hold both status bits");
   end
   if (WINDOW < 1) begin : g_bad_window
      $error("cfg_guard: WINDOW must be at least one instruction");
   end
   if (SIG_IO == SIG_FLASH) begin : g_bad_sig
      $error("cfg_guard: the two signatures must differ");
   end

   logic       open_req;
   lock_mode_t open_mode;
   lock_mode_t mode;

   cfg_guard_decode #(
      .DATA_W   (DATA_W),
      .SIG_IO   (SIG_IO),
      .SIG_FLASH(SIG_FLASH)
   ) u_decode (
      .wr_en    (prot_wr_en),
      .wr_is_dma(wr_is_dma),
      .wr_data  (wr_data),
      .open_req (open_req),
      .open_mode(open_mode)
   );

   cfg_guard_window #(
      .WINDOW(WINDOW)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_req (open_req),
      .open_mode(open_mode),
      .retire   (retire_strobe),
      .cancel   (dmem_wr_strobe || sleep_strobe),
      .mode     (mode)
   );

   cfg_guard_readback #(
      .DATA_W(DATA_W)
   ) u_readback (
      .mode   (mode),
      .rd_data(rd_data)
   );

   assign io_unlock    = (mode == LOCK_IO);
   assign flash_unlock = (mode == LOCK_FLASH);
   assign irq_hold     = io_unlock || flash_unlock;

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_unlock && flash_unlock)); // R9
   AST_OPEN_IO: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr_en && !wr_is_dma && wr_data == SIG_IO) |=> io_unlock); // R2
   AST_OPEN_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr_en && !wr_is_dma && wr_data == SIG_FLASH) |=> flash_unlock); // R3
   AST_DMA_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr_en && wr_is_dma && !irq_hold) |=> !irq_hold); // R6
   AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hold == (rd_data[STAT_IO_BIT] || rd_data[STAT_FLASH_BIT])); // R10
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:2] == '0); // R11
endmodule

// File: tb/cfg_guard_tb.sv
module cfg_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prot_wr_en = 1'b0;
   logic       wr_is_dma = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       retire_strobe = 1'b0;
   logic       dmem_wr_strobe = 1'b0;
   logic       sleep_strobe = 1'b0;
   logic [7:0] rd_data;
   logic       io_unlock;
   logic       flash_unlock;
   logic       irq_hold;

   int checks = 0;
   int errors = 0;

   // model: 0 none, 1 io, 2 flash
   int m_mode = 0;
   int m_cnt  = 0;

   always #10 clk = ~clk;

   cfg_guard u_dut (
      .clk(clk), .rst_n(rst_n), .prot_wr_en(prot_wr_en), .wr_is_dma(wr_is_dma),
      .wr_data(wr_data), .retire_strobe(retire_strobe),
      .dmem_wr_strobe(dmem_wr_strobe), .sleep_strobe(sleep_strobe),
      .rd_data(rd_data), .io_unlock(io_unlock), .flash_unlock(flash_unlock),
      .irq_hold(irq_hold)
   );

   function automatic logic [10:0] expect_vec(int md);
      logic [7:0] rd;
      rd = (md == 1) ? 8'h01 : (md == 2) ? 8'h02 : 8'h00;
      return {rd, md != 0, md == 2, md == 1};
   endfunction

   task automatic chk(string tag);
      logic [10:0] act, exp;
      act = {rd_data, irq_hold, flash_unlock, io_unlock};
      exp = expect_vec(m_mode);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (R10 R11 outputs): actual rd=%h hold=%b fl=%b io=%b expected rd=%h hold=%b fl=%b io=%b",
                  tag, act[10:3], act[2], act[1], act[0], exp[10:3], exp[2], exp[1], exp[0]);
      end
   endtask

   task automatic model_step(logic we, logic dma, logic [7:0] d, logic ret, logic dm, logic sl);
      if (we && !dma && d == 8'hD8) begin m_mode = 1; m_cnt = 0; end
      else if (we && !dma && d == 8'h9D) begin m_mode = 2; m_cnt = 0; end
      else if (m_mode == 2 && (dm || sl)) begin m_mode = 0; m_cnt = 0; end
      else if (m_mode != 0 && ret) begin
         if (m_cnt == 3) begin m_mode = 0; m_cnt = 0; end
         else m_cnt++;
      end
   endtask

   task automatic step(string tag, logic we, logic dma, logic [7:0] d,
                       logic ret, logic dm, logic sl);
      prot_wr_en = we; wr_is_dma = dma; wr_data = d;
      retire_strobe = ret; dmem_wr_strobe = dm; sleep_strobe = sl;
      @(posedge clk);
      model_step(we, dma, d, ret, dm, sl);
      @(negedge clk);
      chk(tag);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, 0, 0, 0);
   endtask

   task automatic retire_n(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, 1, 0, 0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5A17;
      void'($urandom(seed));
      #35;
      @(negedge clk);
      chk("R1 reset");
      rst_n = 1'b1;
      idle("R1 idle after reset", 2);

      // R2 open io, R4 count four retires, retire in the write cycle ignored
      step("R2 io signature", 1, 0, 8'hD8, 1, 0, 0);
      retire_n("R4 window running", 3);
      step("R4 fourth retire closes", 0, 0, 8'h00, 1, 0, 0);
      idle("R4 stays closed", 2);

      // R3 flash mode, R5 no retire keeps it open
      step("R3 flash signature", 1, 0, 8'h9D, 0, 0, 0);
      idle("R5 no retire stays open", 20);
      retire_n("R3 flash window runs", 3);
      step("R3 flash closes", 0, 0, 8'h00, 1, 0, 0);

      // R6 DMA signatures ignored; DMA write during window no effect
      step("R6 dma io sig ignored", 1, 1, 8'hD8, 0, 0, 0);
      step("R6 dma flash sig ignored", 1, 1, 8'h9D, 0, 0, 0);
      step("R6 open io", 1, 0, 8'hD8, 0, 0, 0);
      retire_n("R6 io running", 3);
      step("R6 dma sig at last retire", 1, 1, 8'hD8, 1, 0, 0);

      // R7 other CPU values: no effect, count preserved
      step("R7 open flash", 1, 0, 8'h9D, 1, 0, 0);
      retire_n("R7 two retires", 2);
      step("R7 junk value", 1, 0, 8'h55, 0, 0, 0);
      step("R7 junk + retire", 1, 0, 8'hD9, 1, 0, 0);
      step("R7 window closed on schedule", 0, 0, 8'h00, 1, 0, 0);
      step("R7 junk while idle", 1, 0, 8'hFF, 1, 0, 0);

      // R8 cancel flash by dmem write and by sleep; io unaffected
      step("R8 open flash", 1, 0, 8'h9D, 0, 0, 0);
      step("R8 dmem write cancels flash", 0, 0, 8'h00, 0, 1, 0);
      step("R8 open flash again", 1, 0, 8'h9D, 0, 0, 0);
      step("R8 sleep cancels flash", 0, 0, 8'h00, 0, 0, 1);
      step("R8 open io", 1, 0, 8'hD8, 0, 0, 0);
      step("R8 dmem write spares io", 0, 0, 8'h00, 0, 1, 0);
      step("R8 sleep spares io", 0, 0, 8'h00, 0, 0, 1);
      retire_n("R8 io closes normally", 4);

      // R9 restart and mode switch, precedence at last retire
      step("R9 open io", 1, 0, 8'hD8, 0, 0, 0);
      retire_n("R9 io three retires", 3);
      step("R9 flash sig on last retire", 1, 0, 8'h9D, 1, 1, 0);
      retire_n("R9 restarted count", 3);
      step("R9 restarted closes", 0, 0, 8'h00, 1, 0, 0);
      step("R9 open flash", 1, 0, 8'h9D, 0, 0, 0);
      step("R9 io sig beats sleep", 1, 0, 8'hD8, 0, 0, 1);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic we, dma, ret, dm, sl;
         logic [7:0] d;
         int pick;
         we  = ($urandom % 5) == 0;
         dma = ($urandom % 10) < 3;
         pick = $urandom % 10;
         d = (pick < 4) ? 8'hD8 : (pick < 8) ? 8'h9D : 8'($urandom);
         ret = $urandom % 2;
         dm  = ($urandom % 10) == 0;
         sl  = ($urandom % 20) == 0;
         step("R4 R6 R7 R8 R9 random", we, dma, d, ret, dm, sl);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule